// File: doc/BRIEF.md
# Interrupt Status and Priority Vector Unit

This block gathers interrupt requests for a serial link peripheral and presents them to a CPU through a small register port. Software sets request bits through a set register. A routing bit in the control register decides where those bits go. In local mode they land in a status register. Any bit set in that register produces a one-cycle interrupt pulse. In remote mode the same bits become a request to send an interrupt packet to the far end of the link. That request is presented as a valid/ready pair that carries the bit vector. Two link error inputs also raise status bits.

The status register is cleared by writing ones to the bits to be cleared. A priority vector register offers a second way to service interrupts. Reading it gives the index of the lowest-numbered pending bit, which is the most urgent, together with a flag that shows whether anything is pending at all. Writing that index back clears the matching bit. When a clear leaves other bits pending, the block pulses the interrupt again so that the handler is re-entered.

Top module: `irq_vec_unit`

## Requirements
- R1: After reset the routing bit reads 0 (remote mode), the status register is 0, `irq_o` and `pkt_valid_o` are 0, and the vector register reads 0x8000_0000.
- R2: Register select `reg_addr_i` is 0 = control, 1 = set, 2 = status, 3 = vector. In local mode (control bit 0 = 1), writing the set register ORs each 1 bit of the written data into the same status bit on the next edge.
- R3: In remote mode, a write of nonzero data to the set register raises `pkt_valid_o` on the next edge, with `pkt_vec_o` equal to the data. The status register is unchanged. A write of zero raises no request.
- R4: While `pkt_valid_o` is high and `pkt_ready_i` is low, `pkt_vec_o` holds stable. Remote writes made during that wait are ORed together. On acceptance they become the next request, or the request drops if there were none.
- R5: Writing the status register clears each status bit written as 1. A set from any source on the same bit in the same cycle wins over the clear.
- R6: `irq_o` is high for exactly one cycle, in the cycle after the edge on which the status register goes from all-zero to nonzero.
- R7: A write to the status or vector register that leaves the status register nonzero pulses `irq_o` for one cycle. A write that leaves it zero gives no pulse.
- R8: Reading the vector register returns in bits [4:0] the index of the lowest-numbered set status bit, and in bit 31 a flag that is 1 when no status bit is set. When the flag is 1, bits [4:0] read 0. All other bits read 0.
- R9: Writing the vector register clears only the status bit whose index is in bits [4:0] of the written data.
- R10: Each cycle that `lerr_i` is high sets status bit 30. Each cycle that `rerr_i` is high sets status bit 31. This happens in either routing mode.
- R11: The set register reads as 0. The control register reads the routing bit in bit 0 and 0 in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register (combinational) |
| lerr_i | input | 1 | Local link error, sets status bit 30 |
| rerr_i | input | 1 | Remote link error, sets status bit 31 |
| irq_o | output | 1 | One-cycle interrupt pulse |
| pkt_valid_o | output | 1 | Interrupt packet request valid |
| pkt_ready_i | input | 1 | Interrupt packet request accepted |
| pkt_vec_o | output | 32 | Bit vector carried by the packet request |

## Verification
Two pairs of functions can meet in a single cycle.

The first pair is an error-input set and a status clear on the same bit. The bench holds `lerr_i` high across a write-one-to-clear of bit 30. It expects the bit to survive, and it expects a re-pulse because the status is still nonzero after the write.

The second pair is a packet handshake and a new remote write, which happen together during the random phase. A behavioural model predicts the outputs and the read data for every cycle. A difference in either the interrupt pulse or the accumulated packet vector is caught on the cycle where it appears.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;
  localparam int unsigned DW = 32;

  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_PEND = 2'd1,
    REG_STAT = 2'd2,
    REG_VEC  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_status_reg.sv
module irq_status_reg #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] status_nxt_o,
  output logic         any_o,
  output logic         any_nxt_o
);
  logic [N-1:0] status_q;

  // set wins over clear on the same bit
  assign status_nxt_o = (status_q & ~clr_i) | set_i;
  assign any_nxt_o    = |status_nxt_o;
  assign any_o        = |status_q;
  assign status_o     = status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) status_q <= '0;
    else         status_q <= status_nxt_o;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int unsigned N  = 32,
  parameter int unsigned VW = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic [VW-1:0] idx_o,
  output logic          none_o
);
  // bit 0 is most urgent: scan downward so the lowest set bit is kept
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = VW'(i);
    end
  end

  assign none_o = ~|vec_i;
endmodule

// File: rtl/irq_pulse_gen.sv
module irq_pulse_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic any_q_i,
  input  logic any_nxt_i,
  input  logic clr_wr_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= (any_nxt_i & ~any_q_i) | (clr_wr_i & any_nxt_i);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_pkt_req.sv
module irq_pkt_req #(
  parameter int unsigned N = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] add_i,
  input  logic         ready_i,
  output logic         valid_o,
  output logic [N-1:0] vec_o
);
  logic [N-1:0] req_q, acc_q, merged;
  logic         valid_q;

  assign merged = acc_q | add_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= '0;
      acc_q   <= '0;
      valid_q <= 1'b0;
    end else if (!valid_q) begin
      req_q   <= add_i;
      valid_q <= |add_i;
    end else if (ready_i) begin
      req_q   <= merged;
      valid_q <= |merged;
      acc_q   <= '0;
    end else begin
      // presented vector held; newcomers wait in the side buffer
      acc_q <= merged;
    end
  end

  assign valid_o = valid_q;
  assign vec_o   = req_q;
endmodule

// File: rtl/irq_vec_unit.sv
module irq_vec_unit
  import irq_vec_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned LERR_BIT = 30,
  parameter int unsigned RERR_BIT = 31
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_we_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  input  logic               lerr_i,
  input  logic               rerr_i,
  output logic               irq_o,
  output logic               pkt_valid_o,
  input  logic               pkt_ready_i,
  output logic [NUM_SRC-1:0] pkt_vec_o
);
  localparam int unsigned VW = $clog2(NUM_SRC);

  logic               ctrl_local_q;
  logic [NUM_SRC-1:0] status_q, status_nxt, set_vec, clr_vec, remote_add;
  logic               any_q, any_nxt, clr_wr;
  logic [VW-1:0]      top_idx;
  logic               none_pend;
  reg_sel_e           sel;

  assign sel = reg_sel_e'(reg_addr_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         ctrl_local_q <= 1'b0;
    else if (reg_we_i && sel == REG_CTRL) ctrl_local_q <= reg_wdata_i[0];
  end

  always_comb begin
    set_vec    = '0;
    clr_vec    = '0;
    remote_add = '0;
    if (reg_we_i) begin
      unique case (sel)
        REG_PEND: begin
          if (ctrl_local_q) set_vec    = reg_wdata_i[NUM_SRC-1:0];
          else              remote_add = reg_wdata_i[NUM_SRC-1:0];
        end
        REG_STAT: clr_vec = reg_wdata_i[NUM_SRC-1:0];
        REG_VEC:  clr_vec = NUM_SRC'(1) << reg_wdata_i[VW-1:0];
        default:  ;
      endcase
    end
    set_vec[LERR_BIT] = set_vec[LERR_BIT] | lerr_i;
    set_vec[RERR_BIT] = set_vec[RERR_BIT] | rerr_i;
  end

  assign clr_wr = reg_we_i && (sel == REG_STAT || sel == REG_VEC);

  irq_status_reg #(.N(NUM_SRC)) u_status (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .set_i       (set_vec),
    .clr_i       (clr_vec),
    .status_o    (status_q),
    .status_nxt_o(status_nxt),
    .any_o       (any_q),
    .any_nxt_o   (any_nxt)
  );

  irq_prio_enc #(.N(NUM_SRC), .VW(VW)) u_enc (
    .vec_i (status_q),
    .idx_o (top_idx),
    .none_o(none_pend)
  );

  irq_pulse_gen u_pulse (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .any_q_i  (any_q),
    .any_nxt_i(any_nxt),
    .clr_wr_i (clr_wr),
    .irq_o    (irq_o)
  );

  irq_pkt_req #(.N(NUM_SRC)) u_pkt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .add_i  (remote_add),
    .ready_i(pkt_ready_i),
    .valid_o(pkt_valid_o),
    .vec_o  (pkt_vec_o)
  );

  always_comb begin
    reg_rdata_o = '0;
    unique case (sel)
      REG_CTRL: reg_rdata_o[0] = ctrl_local_q;
      REG_STAT: reg_rdata_o[NUM_SRC-1:0] = status_q;
      REG_VEC: begin
        reg_rdata_o[VW-1:0] = top_idx;
        reg_rdata_o[DW-1]   = none_pend;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_vec_unit_chk.sv
module irq_vec_unit_chk
  import irq_vec_pkg::*;
#(
  parameter int unsigned NUM_SRC  = 32,
  parameter int unsigned LERR_BIT = 30
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reg_we_i,
  input logic [1:0]         reg_addr_i,
  input logic [DW-1:0]      reg_wdata_i,
  input logic [DW-1:0]      reg_rdata_o,
  input logic               lerr_i,
  input logic               irq_o,
  input logic               pkt_valid_o,
  input logic               pkt_ready_i,
  input logic [NUM_SRC-1:0] pkt_vec_o,
  input logic               ctrl_local_q,
  input logic [NUM_SRC-1:0] status_q
);
  p_local_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && reg_addr_i == REG_PEND && ctrl_local_q) |=>
      ((status_q & $past(reg_wdata_i[NUM_SRC-1:0])) == $past(reg_wdata_i[NUM_SRC-1:0])));

  p_pkt_nonzero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pkt_valid_o |-> (pkt_vec_o != '0));

  p_pkt_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_o && !pkt_ready_i) |=> (pkt_valid_o && $stable(pkt_vec_o)));

  p_irq_has_src_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_q != '0));

  p_irq_on_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(|status_q) |-> irq_o);

  p_vec_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_addr_i == REG_VEC) |-> (reg_rdata_o[DW-1] == (status_q == '0)));

  p_lerr_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lerr_i |=> status_q[LERR_BIT]);
endmodule

bind irq_vec_unit irq_vec_unit_chk #(.NUM_SRC(NUM_SRC), .LERR_BIT(LERR_BIT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_we_i    (reg_we_i),
  .reg_addr_i  (reg_addr_i),
  .reg_wdata_i (reg_wdata_i),
  .reg_rdata_o (reg_rdata_o),
  .lerr_i      (lerr_i),
  .irq_o       (irq_o),
  .pkt_valid_o (pkt_valid_o),
  .pkt_ready_i (pkt_ready_i),
  .pkt_vec_o   (pkt_vec_o),
  .ctrl_local_q(ctrl_local_q),
  .status_q    (status_q)
);

// File: tb/irq_vec_unit_bench.sv
`timescale 1ns/1ps
module irq_vec_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        lerr = 1'b0, rerr = 1'b0;
  logic        irq, pkt_valid;
  logic        pkt_ready = 1'b0;
  logic [31:0] pkt_vec;

  int checks = 0;
  int failures = 0;
  bit run_cmp = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_vec_unit u_irq_vec_unit (
    .clk_i(clk), .rst_ni(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .lerr_i(lerr), .rerr_i(rerr),
    .irq_o(irq), .pkt_valid_o(pkt_valid), .pkt_ready_i(pkt_ready),
    .pkt_vec_o(pkt_vec)
  );

  // behavioural reference
  bit        m_local;
  bit [31:0] m_status, m_req, m_acc;
  bit        m_valid, m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_local <= 0; m_status <= 0; m_req <= 0; m_acc <= 0;
      m_valid <= 0; m_irq <= 0;
    end else begin
      bit [31:0] set, clr, rem, ns, nreq, nacc;
      bit nloc, nvalid, clrw;
      set = 0; clr = 0; rem = 0; nloc = m_local; clrw = 0;
      if (we) begin
        case (addr)
          2'd0: nloc = wdata[0];
          2'd1: if (m_local) set = wdata; else rem = wdata;
          2'd2: begin clr = wdata; clrw = 1; end
          2'd3: begin clr = 32'd1 << wdata[4:0]; clrw = 1; end
        endcase
      end
      if (lerr) set[30] = 1;
      if (rerr) set[31] = 1;
      ns = (m_status & ~clr) | set;
      nreq = m_req; nacc = m_acc; nvalid = m_valid;
      if (!m_valid) begin nreq = rem; nvalid = (rem != 0); end
      else if (pkt_ready) begin
        nreq = m_acc | rem; nvalid = ((m_acc | rem) != 0); nacc = 0;
      end else nacc = m_acc | rem;
      m_irq    <= (ns != 0) && (m_status == 0 || clrw);
      m_status <= ns;
      m_local  <= nloc;
      m_req <= nreq; m_acc <= nacc; m_valid <= nvalid;
    end
  end

  function automatic bit [31:0] exp_rd(input bit [1:0] a);
    bit [31:0] r = 0;
    case (a)
      2'd0: r = {31'd0, m_local};
      2'd1: r = 0;
      2'd2: r = m_status;
      2'd3: begin
        if (m_status == 0) r = 32'h8000_0000;
        else for (int i = 31; i >= 0; i--) if (m_status[i]) r = i;
      end
    endcase
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    if (rst_n && run_cmp) begin
      #6;
      chk(irq === m_irq, "R6 R7 irq_o", {31'd0, irq}, {31'd0, m_irq});
      chk(pkt_valid === m_valid, "R3 R4 pkt_valid_o", {31'd0, pkt_valid}, {31'd0, m_valid});
      if (m_valid) chk(pkt_vec === m_req, "R4 pkt_vec_o", pkt_vec, m_req);
      chk(rdata === exp_rd(addr), "R2 R8 R11 rdata", rdata, exp_rd(addr));
    end
  end

  task automatic wr(input bit [1:0] a, input bit [31:0] d);
    @(negedge clk); we = 1; addr = a; wdata = d;
    @(negedge clk); we = 0; wdata = '0;
  endtask

  task automatic rd(input bit [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (1000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    rd(2'd3, v); chk(v == 32'h8000_0000, "R1 vector after reset", v, 32'h8000_0000);
    rd(2'd0, v); chk(v == 0, "R1 control after reset", v, 0);
    chk(!irq && !pkt_valid, "R1 outputs after reset", {30'd0, irq, pkt_valid}, 0);
    run_cmp = 1'b1;

    // R3 R4 remote requests with back-pressure
    wr(2'd1, 32'h5);
    chk(pkt_valid && pkt_vec == 32'h5, "R3 remote request", pkt_vec, 32'h5);
    rd(2'd2, v); chk(v == 0, "R3 status untouched", v, 0);
    wr(2'd1, 32'h100);
    chk(pkt_vec == 32'h5, "R4 vector held", pkt_vec, 32'h5);
    pkt_ready = 1'b1; idle(1);
    chk(pkt_valid && pkt_vec == 32'h100, "R4 accumulated follow-up", pkt_vec, 32'h100);
    idle(1); pkt_ready = 1'b0;
    chk(!pkt_valid, "R4 request drops", {31'd0, pkt_valid}, 0);
    wr(2'd1, 32'h0);
    chk(!pkt_valid, "R3 zero write no request", {31'd0, pkt_valid}, 0);

    // R2 R6 R8 R9 R7 local mode
    wr(2'd0, 32'h1);
    rd(2'd0, v); chk(v == 1, "R11 control readback", v, 1);
    rd(2'd1, v); chk(v == 0, "R11 set reg reads zero", v, 0);
    wr(2'd1, 32'h12);
    chk(irq, "R6 pulse on rise", {31'd0, irq}, 1);
    rd(2'd2, v); chk(v == 32'h12, "R2 status set", v, 32'h12);
    rd(2'd3, v); chk(v == 1, "R8 top vector", v, 1);
    idle(1);
    chk(!irq, "R6 single cycle", {31'd0, irq}, 0);
    wr(2'd3, 32'h1);
    rd(2'd2, v); chk(v == 32'h10, "R9 vector clear", v, 32'h10);
    chk(irq, "R7 re-pulse after vector write", {31'd0, irq}, 1);
    rd(2'd3, v); chk(v == 4, "R8 next vector", v, 4);
    wr(2'd2, 32'h10);
    chk(!irq, "R7 no pulse when empty", {31'd0, irq}, 0);
    rd(2'd3, v); chk(v == 32'h8000_0000, "R8 empty flag", v, 32'h8000_0000);

    // R5 set wins over same-cycle clear
    lerr = 1'b1;
    wr(2'd2, 32'h4000_0000);
    lerr = 1'b0;
    rd(2'd2, v); chk(v == 32'h4000_0000, "R5 set beats clear", v, 32'h4000_0000);
    chk(irq, "R7 re-pulse on status write", {31'd0, irq}, 1);
    wr(2'd2, 32'h4000_0000);
    rd(2'd2, v); chk(v == 0, "R5 w1c clears", v, 0);

    // R10 error in remote mode
    wr(2'd0, 32'h0);
    rerr = 1'b1; idle(1); rerr = 1'b0;
    rd(2'd2, v); chk(v == 32'h8000_0000, "R10 remote error sets bit 31", v, 32'h8000_0000);
    chk(irq && !pkt_valid, "R10 local pulse only", {30'd0, irq, pkt_valid}, 32'h2);
    wr(2'd3, 32'd31);

    // random traffic judged by the model
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      we = ($urandom_range(0, 2) != 0);
      addr = 2'($urandom_range(0, 3));
      wdata = ($urandom_range(0, 1) != 0) ? (32'd1 << $urandom_range(0, 31)) : $urandom;
      lerr = ($urandom_range(0, 9) == 0);
      rerr = ($urandom_range(0, 9) == 0);
      pkt_ready = ($urandom_range(0, 2) == 0);
    end
    @(negedge clk); we = 0; lerr = 0; rerr = 0; pkt_ready = 0;
    idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule